// File: doc/BRIEF.md
# Rate-Converting Time-Slot Interchanger

This block is a time-division switch for serial streams that carry 8-bit channels in a fixed 125 µs frame. Each of its input and output streams runs at one of three bit rates, so a stream holds 32, 64 or 128 channels per frame. Any channel of any input stream can be placed into any channel slot of any output stream, including between streams at different rates. The block turns serial input into bytes, stores them in a data memory that keeps three frames, and serialises the chosen bytes onto the outputs.

All timing comes from one internal bit clock that is eight times the 128-channel channel rate, so a frame is 1024 clock cycles long. A frame pulse marks the first cycle of a frame. Slower streams take one bit every two or four clocks. Every input stream can be shifted later by a few clocks to match its frame alignment.

A register port sets the rates, the input offsets and one connection word per output slot. The connection word picks the source, or a constant message byte. It also selects minimum-latency or fixed two-frame delay and turns the slot's drive enable on or off.

Top module: `tsi_switch`

## Requirements
- R1: During reset and after it, until a connection word enables a slot, every `out_en` bit is 0 and every `ser_out` bit is 0. Reset clears all rates, offsets and connection words to zero.
- R2: A frame is 1024 clock cycles. Cycle 0 is the cycle in which `frame_i` is high, and without a pulse the count wraps by itself. Rate code 0 gives 32 channels with a 4-clock bit period, code 1 gives 64 channels with a 2-clock bit period, and codes 2 and 3 give 128 channels with a 1-clock bit period. Bits go MSB first, and channel k starts at cycle k·8·P.
- R3: A byte received on any input stream and channel appears on the output slot whose connection word names that source, whatever the rates of the two streams.
- R4: A slot with the delay bit clear (variable delay) takes the source byte of the current input frame if that channel has fully arrived by the slot's first cycle, and otherwise the byte from the input frame before.
- R5: A slot with the delay bit set (constant delay) always takes the source byte from the input frame two frames before the output frame, so all channels of a frame keep the same relative delay.
- R6: A slot with the message bit set sends the low 8 bits of its connection word in place of switched data.
- R7: A slot whose enable bit is clear drives `out_en` low and `ser_out` low for its whole duration. The enable only changes at the start of a channel.
- R8: Input stream s is sampled as though its frame began `ofs_s` clocks after cycle 0, for `ofs_s` from 0 to 7. A byte that arrives in the first `ofs_s` cycles of a frame belongs to the previous input frame.
- R9: A write with address bit 9 clear stores `wr_data[11:0]` as the connection word of output stream `wr_addr[8:7]`, channel `wr_addr[6:0]`. The word holds message bit 11, constant-delay bit 10, enable bit 9, source stream in bits 8:7 and source channel in bits 6:0. Address `0x200+s` sets input rate `wr_data[1:0]` and input offset `wr_data[6:4]` of stream s. Address `0x204+o` sets the rate `wr_data[1:0]` of output stream o.
- R10: The output bit and the enable for a bit period appear on the ports one clock after the first cycle of that bit period, and they hold until the next bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 1024 cycles per frame |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | High in the first cycle of a frame |
| ser_in | input | 4 | Serial data, one bit per input stream |
| ser_out | output | 4 | Serial data, one bit per output stream |
| out_en | output | 4 | Per-slot drive enable, one bit per output stream |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Register write address |
| wr_data | input | 16 | Register write data |

## Verification
The assertions assume a frame pulse that is either absent or arrives exactly every 1024 cycles. They also assume rates and offsets change only while no frame is running. If a pulse came mid-frame, or a rate changed during a frame, the frame counter would jump, and the checks on byte spacing and frame advance would no longer hold. The bench follows both rules: each scenario resets the block, programs every register with the pulse held low, and only then starts frames with pulses at a fixed 1024-cycle spacing. It picks source channels inside the channel count of the source stream, so every slot it reads has been filled.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int NBUF = 3;

    typedef logic [1:0] buf_t;

    function automatic buf_t buf_inc(buf_t b);
        return (b == 2'd2) ? 2'd0 : b + 2'd1;
    endfunction

    function automatic buf_t buf_dec(buf_t b);
        return (b == 2'd0) ? 2'd2 : b - 2'd1;
    endfunction

    // log2 of the bit period in clocks for a rate code
    function automatic logic [1:0] rate_shift(logic [1:0] r);
        case (r)
            2'd0:    return 2'd2;
            2'd1:    return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/tsi_timebase.sv
module tsi_timebase
    import tsi_pkg::*;
#(
    parameter int T_W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_i,
    output logic [T_W-1:0] cur_t,
    output buf_t           cur_fr
);

    typedef struct packed {
        logic [T_W-1:0] t;
        buf_t           fr;
    } tb_s;

    tb_s tb_d, tb_q;
    logic start;

    always_comb begin
        start  = frame_i || (tb_q.t == '0);
        cur_t  = frame_i ? '0 : tb_q.t;
        cur_fr = start ? buf_inc(tb_q.fr) : tb_q.fr;
        tb_d.t  = cur_t + T_W'(1);
        tb_d.fr = cur_fr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    // the last cycle of a frame is always followed by a new frame buffer index
    assert_frame_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_t == '1) |=> (cur_fr != $past(cur_fr)));

endmodule

// File: rtl/tsi_rx_lane.sv
module tsi_rx_lane
    import tsi_pkg::*;
#(
    parameter int T_W   = 10,
    parameter int CH_W  = 7,
    parameter int OFS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [T_W-1:0]   cur_t,
    input  buf_t             cur_fr,
    input  logic [1:0]       rate,
    input  logic [OFS_W-1:0] ofs,
    input  logic             din,
    output logic             wr_en,
    output buf_t             wr_buf,
    output logic [CH_W-1:0]  wr_chan,
    output logic [7:0]       wr_byte,
    output logic [CH_W-1:0]  cur_chan,
    output buf_t             cur_buf
);

    logic [7:0]     acc_d, acc_q;
    logic [1:0]     sh;
    logic [T_W-1:0] u, us, pmask;
    logic           sample;

    always_comb begin
        sh       = rate_shift(rate);
        u        = cur_t - T_W'(ofs);
        us       = u >> sh;
        pmask    = (T_W'(1) << sh) - T_W'(1);
        sample   = (u & pmask) == pmask;
        cur_buf  = (cur_t >= T_W'(ofs)) ? cur_fr : buf_dec(cur_fr);
        cur_chan = us[T_W-1:3];
        acc_d    = sample ? {acc_q[6:0], din} : acc_q;
        wr_en    = sample && (us[2:0] == 3'd7);
        wr_byte  = {acc_q[6:0], din};
        wr_chan  = cur_chan;
        wr_buf   = cur_buf;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // a whole byte needs eight samples, so completions never come back to back
    assert_rx_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane
    import tsi_pkg::*;
#(
    parameter int T_W  = 10,
    parameter int CH_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [T_W-1:0]  cur_t,
    input  logic [1:0]      rate,
    input  logic [7:0]      lk_byte,
    input  logic            lk_oe,
    output logic            ld,
    output logic [CH_W-1:0] ld_chan,
    output logic            ser_o,
    output logic            en_o
);

    typedef struct packed {
        logic [7:0] sh;
        logic       bit_o;
        logic       en;
    } tx_s;

    tx_s tx_d, tx_q;
    logic [1:0]     sh;
    logic [T_W-1:0] ts, pmask;
    logic           bnd;

    always_comb begin
        sh      = rate_shift(rate);
        ts      = cur_t >> sh;
        pmask   = (T_W'(1) << sh) - T_W'(1);
        bnd     = (cur_t & pmask) == '0;
        ld      = bnd && (ts[2:0] == 3'd0);
        ld_chan = ts[T_W-1:3];
        tx_d    = tx_q;
        if (ld) begin
            tx_d.en    = lk_oe;
            tx_d.bit_o = lk_byte[7] & lk_oe;
            tx_d.sh    = {lk_byte[6:0], 1'b0};
        end else if (bnd) begin
            tx_d.bit_o = tx_q.sh[7] & tx_q.en;
            tx_d.sh    = {tx_q.sh[6:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign ser_o = tx_q.bit_o;
    assign en_o  = tx_q.en;

    assert_tx_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o |-> !ser_o);

    assert_tx_en_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(en_o));

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int NUM_IN  = 4,
    parameter int NUM_OUT = 4,
    parameter int MAX_CH  = 128,
    parameter int OFS_W   = 3,
    parameter int DATA_W  = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  frame_i,
    input  logic [NUM_IN-1:0]                     ser_in,
    output logic [NUM_OUT-1:0]                    ser_out,
    output logic [NUM_OUT-1:0]                    out_en,
    input  logic                                  wr_en,
    input  logic [$clog2(NUM_OUT)+$clog2(MAX_CH):0] wr_addr,
    input  logic [DATA_W-1:0]                     wr_data
);

    localparam int CH_W   = $clog2(MAX_CH);
    localparam int T_W    = CH_W + 3;
    localparam int IS_W   = $clog2(NUM_IN);
    localparam int OS_W   = $clog2(NUM_OUT);
    localparam int ADDR_W = 1 + OS_W + CH_W;
    localparam int SEL_B  = (IS_W > OS_W) ? IS_W : OS_W;
    localparam int ENT_W  = 3 + IS_W + CH_W;
    localparam int OE_B   = CH_W + IS_W;
    localparam int CST_B  = OE_B + 1;
    localparam int MSG_B  = OE_B + 2;

    typedef struct packed {
        logic [NUM_IN-1:0][1:0]       in_rate;
        logic [NUM_IN-1:0][OFS_W-1:0] in_ofs;
        logic [NUM_OUT-1:0][1:0]      out_rate;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [ENT_W-1:0] cm_q [NUM_OUT][MAX_CH];
    logic [7:0]       dm_q [NBUF][NUM_IN][MAX_CH];

    logic [T_W-1:0] cur_t;
    buf_t           cur_fr;

    logic            rx_wr   [NUM_IN];
    buf_t            rx_buf  [NUM_IN];
    logic [CH_W-1:0] rx_chan [NUM_IN];
    logic [7:0]      rx_byte [NUM_IN];
    logic [CH_W-1:0] rx_cur_chan [NUM_IN];
    buf_t            rx_cur_buf  [NUM_IN];

    logic            tx_ld      [NUM_OUT];
    logic [CH_W-1:0] tx_ld_chan [NUM_OUT];
    logic [7:0]      lk_byte    [NUM_OUT];
    logic            lk_oe      [NUM_OUT];

    tsi_timebase #(.T_W(T_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .frame_i(frame_i),
        .cur_t(cur_t), .cur_fr(cur_fr)
    );

    // configuration registers
    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && wr_addr[ADDR_W-1]) begin
            for (int i = 0; i < NUM_IN; i++) begin
                if (!wr_addr[SEL_B] && (wr_addr[SEL_B-1:0] == SEL_B'(i))) begin
                    cfg_d.in_rate[i] = wr_data[1:0];
                    cfg_d.in_ofs[i]  = wr_data[4 +: OFS_W];
                end
            end
            for (int o = 0; o < NUM_OUT; o++) begin
                if (wr_addr[SEL_B] && (wr_addr[SEL_B-1:0] == SEL_B'(o)))
                    cfg_d.out_rate[o] = wr_data[1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // connection memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int o = 0; o < NUM_OUT; o++)
                for (int c = 0; c < MAX_CH; c++)
                    cm_q[o][c] <= '0;
        end else if (wr_en && !wr_addr[ADDR_W-1]) begin
            cm_q[wr_addr[CH_W +: OS_W]][wr_addr[CH_W-1:0]] <= wr_data[ENT_W-1:0];
        end
    end

    // receive lanes and data memory
    for (genvar i = 0; i < NUM_IN; i++) begin : g_rx
        tsi_rx_lane #(.T_W(T_W), .CH_W(CH_W), .OFS_W(OFS_W)) u_rx (
            .clk(clk), .rst_n(rst_n), .cur_t(cur_t), .cur_fr(cur_fr),
            .rate(cfg_q.in_rate[i]), .ofs(cfg_q.in_ofs[i]), .din(ser_in[i]),
            .wr_en(rx_wr[i]), .wr_buf(rx_buf[i]), .wr_chan(rx_chan[i]),
            .wr_byte(rx_byte[i]), .cur_chan(rx_cur_chan[i]), .cur_buf(rx_cur_buf[i])
        );

        always_ff @(posedge clk) begin
            if (rx_wr[i]) dm_q[rx_buf[i]][i][rx_chan[i]] <= rx_byte[i];
        end

        // constant-delay reads use a buffer no receiver is filling
        assert_const_buf_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
            rx_wr[i] |-> (rx_buf[i] != buf_inc(cur_fr)));
    end

    // lookup and transmit lanes
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_tx
        logic [ENT_W-1:0] ent;
        logic [IS_W-1:0]  src_s;
        logic [CH_W-1:0]  src_c;
        buf_t             vbuf, rbuf;

        always_comb begin
            ent    = cm_q[o][tx_ld_chan[o]];
            src_s  = ent[CH_W +: IS_W];
            src_c  = ent[CH_W-1:0];
            vbuf   = (src_c < rx_cur_chan[src_s]) ? rx_cur_buf[src_s]
                                                  : buf_dec(rx_cur_buf[src_s]);
            rbuf   = ent[CST_B] ? buf_inc(cur_fr) : vbuf;
            lk_byte[o] = ent[MSG_B] ? ent[7:0] : dm_q[rbuf][src_s][src_c];
            lk_oe[o]   = ent[OE_B];
        end

        tsi_tx_lane #(.T_W(T_W), .CH_W(CH_W)) u_tx (
            .clk(clk), .rst_n(rst_n), .cur_t(cur_t), .rate(cfg_q.out_rate[o]),
            .lk_byte(lk_byte[o]), .lk_oe(lk_oe[o]),
            .ld(tx_ld[o]), .ld_chan(tx_ld_chan[o]),
            .ser_o(ser_out[o]), .en_o(out_en[o])
        );
    end

endmodule

// File: tb/tsi_switch_test.sv
module tsi_switch_test;

    localparam int CLK_P = 10;
    localparam int FR    = 1024;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        frame_i = 0;
    logic [3:0]  ser_in = '0;
    logic [3:0]  ser_out, out_en;
    logic        wr_en = 0;
    logic [9:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;

    int n_run = 0, n_fail = 0;

    logic [11:0] ent [4][128];
    int in_rate[4], in_ofs[4], out_rate[4];
    int bad_d, bad_e, fm_act, fm_exp, fm_tc;

    always #(CLK_P/2) clk = ~clk;

    tsi_switch uut (
        .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .ser_in(ser_in),
        .ser_out(ser_out), .out_en(out_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic int shf(int r);
        return (r == 0) ? 2 : (r == 1) ? 1 : 0;
    endfunction

    function automatic logic [7:0] gen(int g, int s, int c);
        int h;
        h = g * 40503 + s * 9973 + c * 131 + 7;
        return 8'(h ^ (h >>> 8) ^ (g * 3));
    endfunction

    // expected {enable, bit} on output o for global cycle tc
    function automatic logic [1:0] model(int tc, int o);
        int f, tt, so, k, b, ss, sc, v, g, cc;
        logic [11:0] e;
        logic [7:0] by;
        f  = tc / FR;
        tt = tc % FR;
        so = shf(out_rate[o]);
        k  = tt >> (so + 3);
        b  = (tt >> so) & 7;
        e  = ent[o][k];
        if (!e[9]) return 2'b00;
        if (e[11]) by = e[7:0];
        else begin
            ss = int'(e[8:7]);
            sc = int'(e[6:0]);
            if (e[10]) g = f - 2;
            else begin
                v  = f * FR + (k << (so + 3)) - in_ofs[ss];
                g  = v / FR;
                cc = (v % FR) >> (shf(in_rate[ss]) + 3);
                if (sc >= cc) g = g - 1;
            end
            by = gen(g, ss, sc);
        end
        return {1'b1, by[7-b]};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; frame_i = 0; ser_in = '0; wr_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wr(logic [9:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
    endtask

    task automatic program_all();
        for (int s = 0; s < 4; s++)
            wr(10'h200 | 10'(s), 16'(in_rate[s] | (in_ofs[s] << 4)));
        for (int o = 0; o < 4; o++)
            wr(10'h204 | 10'(o), 16'(out_rate[o]));
        for (int o = 0; o < 4; o++)
            for (int c = 0; c < 128; c++)
                wr({1'b0, 2'(o), 7'(c)}, {4'b0, ent[o][c]});
        @(negedge clk);
        wr_en = 0;
    endtask

    // msg, cst, oe flags: 0 clear, 1 set, 2 random
    task automatic make_entries(int msg, int cst, int oe);
        for (int o = 0; o < 4; o++)
            for (int c = 0; c < 128; c++) begin
                int ss, sc;
                logic m, k, e;
                ss = int'($urandom % 4);
                sc = int'($urandom % (128 >> shf(in_rate[ss])));
                m  = (msg == 2) ? 1'($urandom) : 1'(msg);
                k  = (cst == 2) ? 1'($urandom) : 1'(cst);
                e  = (oe  == 2) ? 1'($urandom) : 1'(oe);
                ent[o][c] = m ? {m, k, e, 1'($urandom), 8'($urandom)}
                              : {m, k, e, 2'(ss), 7'(sc)};
            end
    endtask

    task automatic drive(int gc);
        frame_i = (gc % FR) == 0;
        for (int s = 0; s < 4; s++) begin
            int v, g, u, sh;
            logic [7:0] by;
            v = gc - in_ofs[s];
            if (v < 0) begin g = -1; u = v + FR; end
            else begin g = v / FR; u = v % FR; end
            sh = shf(in_rate[s]);
            by = gen(g, s, u >> (sh + 3));
            ser_in[s] = by[7 - ((u >> sh) & 7)];
        end
    endtask

    task automatic run(int nfr);
        bad_d = 0; bad_e = 0;
        for (int gc = 0; gc <= nfr * FR; gc++) begin
            @(negedge clk);
            if (gc - 1 >= 3 * FR) begin
                for (int o = 0; o < 4; o++) begin
                    logic [1:0] x;
                    x = model(gc - 1, o);
                    if (out_en[o] !== x[1]) bad_e++;
                    if (ser_out[o] !== x[0]) begin
                        if (bad_d == 0) begin
                            fm_act = int'(ser_out[o]); fm_exp = int'(x[0]); fm_tc = gc - 1;
                        end
                        bad_d++;
                    end
                end
            end
            if (gc < nfr * FR) drive(gc);
            else frame_i = 0;
        end
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        check(out_en == 4'b0 && ser_out == 4'b0, "R1 during reset", int'(out_en), 0);
        rst_n = 1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            drive(i);
            if (out_en != 4'b0 || ser_out != 4'b0) begin
                check(0, "R1 idle after reset", int'({out_en, ser_out}), 0);
                break;
            end
        end
        check(out_en == 4'b0 && ser_out == 4'b0, "R1 idle after reset", int'(out_en), 0);
    endtask

    task automatic t_same_rate();
        do_reset();
        for (int s = 0; s < 4; s++) begin in_rate[s] = 2; in_ofs[s] = 0; out_rate[s] = 2; end
        make_entries(0, 0, 1);
        program_all();
        run(6);
        check(bad_d == 0, "R3 same-rate switching", fm_act, fm_exp);
        check(bad_e == 0, "R10 enable timing", bad_e, 0);
    endtask

    task automatic t_mixed_rate();
        do_reset();
        in_rate  = '{0, 1, 2, 3};
        out_rate = '{2, 0, 3, 1};
        in_ofs   = '{0, 0, 0, 0};
        make_entries(0, 0, 1);
        program_all();
        run(6);
        check(bad_d == 0, "R2 rate conversion", fm_act, fm_exp);
        check(bad_d == 0, "R4 variable delay", bad_d, 0);
    endtask

    task automatic t_const();
        do_reset();
        in_rate  = '{2, 0, 1, 2};
        out_rate = '{1, 2, 0, 2};
        in_ofs   = '{0, 2, 0, 6};
        make_entries(0, 1, 1);
        program_all();
        run(7);
        check(bad_d == 0, "R5 constant delay", fm_act, fm_exp);
        check(bad_e == 0, "R5 enable", bad_e, 0);
    endtask

    task automatic t_offset();
        do_reset();
        in_rate  = '{2, 1, 0, 2};
        out_rate = '{2, 2, 1, 0};
        in_ofs   = '{0, 3, 5, 7};
        make_entries(0, 2, 1);
        program_all();
        run(6);
        check(bad_d == 0, "R8 input offset", fm_act, fm_exp);
        check(bad_e == 0, "R8 enable", bad_e, 0);
    endtask

    task automatic t_msg_oe();
        do_reset();
        in_rate  = '{1, 2, 2, 0};
        out_rate = '{2, 1, 0, 2};
        in_ofs   = '{1, 0, 4, 0};
        make_entries(2, 2, 2);
        program_all();
        run(6);
        check(bad_d == 0, "R6 message byte", fm_act, fm_exp);
        check(bad_e == 0, "R7 per-slot enable", bad_e, 0);
        check(bad_d == 0 && bad_e == 0, "R9 register layout", bad_d + bad_e, 0);
    endtask

    initial begin
        #(CLK_P * 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int s = 0; s < 4; s++) begin in_rate[s] = 0; in_ofs[s] = 0; out_rate[s] = 0; end
        for (int o = 0; o < 4; o++) for (int c = 0; c < 128; c++) ent[o][c] = '0;
        t_reset();
        t_same_rate();
        t_mixed_rate();
        t_const();
        t_offset();
        t_msg_oe();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule